// File: doc/BRIEF.md
# Page-Aware Instruction Prefetch Window

This block keeps a small window of instruction bytes, CACHE_SIZE bytes long, that sits inside PAGE_SIZE-byte pages. It stores the linear address at which the window starts and a bit that says whether the stored bytes can be trusted. Each fetch request carries a linear address, the segment-relative offset, the segment limit, a byte count and a flag that marks instruction fetches. The block then picks one of three paths. It may refill the window from memory and return the requested bytes from it. It may place the window start lower so the window stays inside one page. Or it may send the request to memory as a plain read of the requested bytes.

Memory is reached through one request/acknowledge port. A request gives an address and a byte count, and the response returns the bytes together with an error flag. Stores that go to memory elsewhere are also shown to the block, which patches any buffered bytes they overwrite. A one-cycle invalidate input, raised on a context switch, drops the window. Segment protection checks and instruction decoding are handled outside the block.

Top module: `prefetch_window`

## Requirements
- R1: After reset, winValid, winBase, memReq and fetchDone are all 0.
- R2: A request with fetchIsInst low, or with fetchOffset + CACHE_SIZE - 1 greater than fetchLimit (computed without wrap-around), becomes a direct read. memAddr is fetchLinAddr, memLen is fetchSize, fetchFromWin is 0, and neither winValid nor winBase changes.
- R3: A request that passes the R2 test sets winBase to a proposed start. The proposed start is fetchLinAddr, unless pagingOn is 1 and the page offset of fetchLinAddr is greater than PAGE_SIZE - CACHE_SIZE. In that case the proposed start is the page-aligned address ORed with PAGE_SIZE - CACHE_SIZE. With pagingOn at 0 the start is never moved.
- R4: If, after the start is chosen, (fetchLinAddr - winBase + fetchSize) is at least CACHE_SIZE, winValid is cleared and the request becomes a direct read with fetchFromWin at 0.
- R5: Any other request that passes the R2 test fills the window. memAddr is winBase and memLen is CACHE_SIZE. On a response without error, winValid becomes 1 and winBytes holds the response. fetchData holds window bytes (fetchLinAddr - winBase) upward, and fetchOk and fetchFromWin are 1.
- R6: A fill whose response has memErr set clears winValid and returns fetchOk 0 with fetchFromWin 1.
- R7: A direct read returns fetchOk equal to the inverse of memErr. fetchData carries the low fetchSize bytes of memRdata.
- R8: A store (wrEn) with winValid set and every byte of [wrAddr, wrAddr+wrSize) inside [winBase, winBase+CACHE_SIZE) replaces window byte wrAddr-winBase+k with byte k of wrData (bits 8k+7:8k) for every k below wrSize. A store that is partly or wholly outside the window, or that arrives while winValid is 0, leaves winBytes unchanged.
- R9: invalidate clears winValid on the next edge, and it wins over a fill completing on the same edge.
- R10: memReq stays high, with memAddr and memLen stable, until memAck is seen. fetchDone pulses for exactly one cycle, on the cycle after the acknowledge. fetchReq is ignored while a request is outstanding.
- R11: Byte j of memRdata (bits 8j+7:8j) is the byte at memAddr+j. Byte k of fetchData is the k-th requested byte counting upward from the lowest address, and bytes at or above fetchSize are 0. Byte i of winBytes is the byte at winBase+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Fetch request strobe, taken when idle |
| fetchLinAddr | input | ADDR_W | Linear address of the first requested byte |
| fetchOffset | input | ADDR_W | Segment-relative offset of the request |
| fetchLimit | input | ADDR_W | Segment limit |
| fetchSize | input | $clog2(FETCH_BYTES+1) | Requested byte count, 1..FETCH_BYTES |
| fetchIsInst | input | 1 | Request is an instruction fetch |
| pagingOn | input | 1 | Paging is enabled |
| fetchDone | output | 1 | One-cycle pulse when the result is ready |
| fetchOk | output | 1 | Result is valid (no memory error) |
| fetchFromWin | output | 1 | Result came through a window fill |
| fetchData | output | FETCH_BYTES*8 | Returned bytes, little-endian |
| memReq | output | 1 | Memory read request, held until acknowledged |
| memAddr | output | ADDR_W | Memory read start address |
| memLen | output | $clog2(CACHE_SIZE+1) | Memory read byte count |
| memAck | input | 1 | Memory response strobe |
| memErr | input | 1 | Memory response error |
| memRdata | input | CACHE_SIZE*8 | Memory response bytes, little-endian |
| wrEn | input | 1 | Store snoop strobe |
| wrAddr | input | ADDR_W | Store linear address |
| wrSize | input | $clog2(WR_BYTES+1) | Store byte count |
| wrData | input | WR_BYTES*8 | Store bytes, little-endian |
| invalidate | input | 1 | Drop the window (context switch) |
| winValid | output | 1 | Window contents are valid |
| winBase | output | ADDR_W | Window start linear address |
| winBytes | output | CACHE_SIZE*8 | Window contents, little-endian |

## Verification
The bench covers every page offset in one page, with paging both on and off and with every fetch size. This catches clamping that is off by one at offset PAGE_SIZE - CACHE_SIZE, which would either push the window across the page or move it when there was no need. The same sweep catches an index error at the last offsets, where the spill check must send the fetch to a direct read and drop the window instead of returning bytes from past the window's end. Offsets on both sides of the segment limit, and an offset near the top of the address space, check that the limit test neither wraps nor misses by one. Stores that straddle the window's edges, a store made while the window is invalid, and an invalidate that arrives on the same edge as a fill acknowledge each check one merge or priority rule that a wrong design would break by leaving stale or corrupted bytes marked valid.

// File: rtl/prefetch_window_pkg.sv
package prefetch_window_pkg;

  // Strobes from control to datapath, one per operation.
  typedef struct packed {
    logic capture;   // latch request, decide path, move window start
    logic loadWin;   // store fill response, window becomes valid
    logic failWin;   // fill returned an error, window dropped
    logic latchRes;  // register result toward the requester
  } pfw_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } pfw_state_e;

endpackage

// File: rtl/pfw_ctrl.sv
module pfw_ctrl
  import prefetch_window_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetchReq,
  input  logic        memAck,
  input  logic        memErr,
  input  logic        reqFill,
  output pfw_strobe_t strb,
  output logic        memReq,
  output logic        fetchDone
);

  pfw_state_e state, stateNext;

  always_comb begin
    strb          = '0;
    stateNext     = state;
    strb.capture  = (state == ST_IDLE) && fetchReq;
    strb.latchRes = (state == ST_WAIT) && memAck;
    strb.loadWin  = strb.latchRes && reqFill && !memErr;
    strb.failWin  = strb.latchRes && reqFill && memErr;
    if (strb.capture)  stateNext = ST_WAIT;
    if (strb.latchRes) stateNext = ST_IDLE;
  end

  assign memReq = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fetchDone <= 1'b0;
    end else begin
      state     <= stateNext;
      fetchDone <= strb.latchRes;
    end
  end

endmodule

// File: rtl/pfw_dpath.sv
module pfw_dpath
  import prefetch_window_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_SIZE  = 16,
  parameter int PAGE_SIZE   = 4096,
  parameter int FETCH_BYTES = 4,
  parameter int WR_BYTES    = 4,
  localparam int CACHE_BITS = $clog2(CACHE_SIZE),
  localparam int PAGE_BITS  = $clog2(PAGE_SIZE),
  localparam int SIZE_W     = $clog2(FETCH_BYTES + 1),
  localparam int WSIZE_W    = $clog2(WR_BYTES + 1),
  localparam int LEN_W      = $clog2(CACHE_SIZE + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  pfw_strobe_t              strb,
  input  logic [ADDR_W-1:0]        fetchLinAddr,
  input  logic [ADDR_W-1:0]        fetchOffset,
  input  logic [ADDR_W-1:0]        fetchLimit,
  input  logic [SIZE_W-1:0]        fetchSize,
  input  logic                     fetchIsInst,
  input  logic                     pagingOn,
  input  logic                     memErr,
  input  logic [CACHE_SIZE*8-1:0]  memRdata,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [WSIZE_W-1:0]       wrSize,
  input  logic [WR_BYTES*8-1:0]    wrData,
  input  logic                     invalidate,
  output logic                     reqFill,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [LEN_W-1:0]         memLen,
  output logic                     fetchOk,
  output logic                     fetchFromWin,
  output logic [FETCH_BYTES*8-1:0] fetchData,
  output logic                     winValid,
  output logic [ADDR_W-1:0]        winBase,
  output logic [CACHE_SIZE*8-1:0]  winBytes
);

  localparam logic [ADDR_W:0]      CACHE_W    = (ADDR_W+1)'(CACHE_SIZE);
  localparam logic [ADDR_W:0]      CACHE_M1_W = (ADDR_W+1)'(CACHE_SIZE - 1);
  localparam logic [PAGE_BITS-1:0] CLAMP_OFF  = PAGE_BITS'(PAGE_SIZE - CACHE_SIZE);

  // ---------------- path decision (combinational on request inputs)
  logic [ADDR_W:0]      offReach;
  logic                 limitOk;
  logic                 tryWin;
  logic                 needClamp;
  logic [ADDR_W-1:0]    propBase;
  logic [ADDR_W-1:0]    propIdx;
  logic [ADDR_W:0]      spanEnd;
  logic                 spills;
  logic                 goFill;
  logic                 killWin;

  always_comb begin
    offReach  = {1'b0, fetchOffset} + CACHE_M1_W;
    limitOk   = offReach <= {1'b0, fetchLimit};
    tryWin    = fetchIsInst && limitOk;
    needClamp = pagingOn && (fetchLinAddr[PAGE_BITS-1:0] > CLAMP_OFF);
    propBase  = needClamp ? {fetchLinAddr[ADDR_W-1:PAGE_BITS], CLAMP_OFF} : fetchLinAddr;
    propIdx   = fetchLinAddr - propBase;
    spanEnd   = {1'b0, propIdx} + (ADDR_W+1)'(fetchSize);
    spills    = spanEnd >= CACHE_W;
    goFill    = tryWin && !spills;
    killWin   = tryWin && spills;
  end

  // ---------------- captured request
  logic [ADDR_W-1:0]     reqLin;
  logic [SIZE_W-1:0]     reqSize;
  logic [CACHE_BITS-1:0] reqIdx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqFill <= 1'b0;
      reqLin  <= '0;
      reqSize <= '0;
      reqIdx  <= '0;
      winBase <= '0;
    end else if (strb.capture) begin
      reqFill <= goFill;
      reqLin  <= fetchLinAddr;
      reqSize <= fetchSize;
      reqIdx  <= propIdx[CACHE_BITS-1:0];
      if (tryWin) winBase <= propBase;
    end
  end

  assign memAddr = reqFill ? winBase : reqLin;
  assign memLen  = reqFill ? LEN_W'(CACHE_SIZE) : LEN_W'(reqSize);

  // ---------------- valid bit: invalidate has top priority
  always_ff @(posedge clk) begin
    if (!rst_n)                        winValid <= 1'b0;
    else if (invalidate)               winValid <= 1'b0;
    else if (strb.capture && killWin)  winValid <= 1'b0;
    else if (strb.loadWin)             winValid <= 1'b1;
    else if (strb.failWin)             winValid <= 1'b0;
  end

  // ---------------- store snoop
  logic [ADDR_W:0]       wrEnd;
  logic [ADDR_W:0]       winEnd;
  logic [ADDR_W-1:0]     wrOff;
  logic                  wrHit;

  always_comb begin
    wrEnd  = {1'b0, wrAddr} + (ADDR_W+1)'(wrSize);
    winEnd = {1'b0, winBase} + CACHE_W;
    wrOff  = wrAddr - winBase;
    wrHit  = wrEn && winValid && (wrSize != '0) && (wrAddr >= winBase) && (wrEnd <= winEnd);
  end

  function automatic logic [7:0] patchByte(input int pos, input logic [7:0] oldByte,
                                           input logic [CACHE_BITS-1:0] offLo,
                                           input logic [WSIZE_W-1:0] sz,
                                           input logic [WR_BYTES*8-1:0] data);
    logic [7:0] r;
    r = oldByte;
    for (int k = 0; k < WR_BYTES; k++) begin
      if ((k < int'(sz)) && ((int'(offLo) + k) == pos)) r = data[8*k +: 8];
    end
    return r;
  endfunction

  logic [7:0] winBuf   [CACHE_SIZE];
  logic [7:0] nextByte [CACHE_SIZE];

  for (genvar i = 0; i < CACHE_SIZE; i++) begin : g_patch
    assign nextByte[i] = wrHit ? patchByte(i, winBuf[i], wrOff[CACHE_BITS-1:0], wrSize, wrData)
                               : winBuf[i];
    assign winBytes[8*i +: 8] = winBuf[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CACHE_SIZE; i++) winBuf[i] <= '0;
    end else if (strb.loadWin) begin
      for (int i = 0; i < CACHE_SIZE; i++) winBuf[i] <= memRdata[8*i +: 8];
    end else begin
      for (int i = 0; i < CACHE_SIZE; i++) winBuf[i] <= nextByte[i];
    end
  end

  // ---------------- result selection
  logic [FETCH_BYTES*8-1:0] resData;

  always_comb begin
    resData = '0;
    for (int k = 0; k < FETCH_BYTES; k++) begin
      if (k < int'(reqSize)) begin
        for (int j = 0; j < CACHE_SIZE; j++) begin
          if (reqFill && (j == int'(reqIdx) + k)) resData[8*k +: 8] = memRdata[8*j +: 8];
        end
        if (!reqFill) resData[8*k +: 8] = memRdata[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetchOk      <= 1'b0;
      fetchFromWin <= 1'b0;
      fetchData    <= '0;
    end else if (strb.latchRes) begin
      fetchOk      <= !memErr;
      fetchFromWin <= reqFill;
      fetchData    <= resData;
    end
  end

endmodule

// File: rtl/prefetch_window.sv
module prefetch_window
  import prefetch_window_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_SIZE  = 16,
  parameter int PAGE_SIZE   = 4096,
  parameter int FETCH_BYTES = 4,
  parameter int WR_BYTES    = 4,
  localparam int SIZE_W     = $clog2(FETCH_BYTES + 1),
  localparam int WSIZE_W    = $clog2(WR_BYTES + 1),
  localparam int LEN_W      = $clog2(CACHE_SIZE + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fetchReq,
  input  logic [ADDR_W-1:0]        fetchLinAddr,
  input  logic [ADDR_W-1:0]        fetchOffset,
  input  logic [ADDR_W-1:0]        fetchLimit,
  input  logic [SIZE_W-1:0]        fetchSize,
  input  logic                     fetchIsInst,
  input  logic                     pagingOn,
  output logic                     fetchDone,
  output logic                     fetchOk,
  output logic                     fetchFromWin,
  output logic [FETCH_BYTES*8-1:0] fetchData,
  output logic                     memReq,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [LEN_W-1:0]         memLen,
  input  logic                     memAck,
  input  logic                     memErr,
  input  logic [CACHE_SIZE*8-1:0]  memRdata,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [WSIZE_W-1:0]       wrSize,
  input  logic [WR_BYTES*8-1:0]    wrData,
  input  logic                     invalidate,
  output logic                     winValid,
  output logic [ADDR_W-1:0]        winBase,
  output logic [CACHE_SIZE*8-1:0]  winBytes
);

  pfw_strobe_t strb;
  logic        reqFill;

  pfw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetchReq  (fetchReq),
    .memAck    (memAck),
    .memErr    (memErr),
    .reqFill   (reqFill),
    .strb      (strb),
    .memReq    (memReq),
    .fetchDone (fetchDone)
  );

  pfw_dpath #(
    .ADDR_W      (ADDR_W),
    .CACHE_SIZE  (CACHE_SIZE),
    .PAGE_SIZE   (PAGE_SIZE),
    .FETCH_BYTES (FETCH_BYTES),
    .WR_BYTES    (WR_BYTES)
  ) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .fetchLinAddr (fetchLinAddr),
    .fetchOffset  (fetchOffset),
    .fetchLimit   (fetchLimit),
    .fetchSize    (fetchSize),
    .fetchIsInst  (fetchIsInst),
    .pagingOn     (pagingOn),
    .memErr       (memErr),
    .memRdata     (memRdata),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrSize       (wrSize),
    .wrData       (wrData),
    .invalidate   (invalidate),
    .reqFill      (reqFill),
    .memAddr      (memAddr),
    .memLen       (memLen),
    .fetchOk      (fetchOk),
    .fetchFromWin (fetchFromWin),
    .fetchData    (fetchData),
    .winValid     (winValid),
    .winBase      (winBase),
    .winBytes     (winBytes)
  );

endmodule

// File: rtl/prefetch_window_checker.sv
module prefetch_window_checker #(
  parameter int ADDR_W     = 32,
  parameter int CACHE_SIZE = 16,
  localparam int LEN_W     = $clog2(CACHE_SIZE + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LEN_W-1:0]  memLen,
  input logic              fetchDone,
  input logic              fetchOk,
  input logic              fetchFromWin,
  input logic              winValid,
  input logic              invalidate
);

  // R10: request held with a stable address and length until acknowledged
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memLen));

  // R10: completion follows acknowledge and lasts one cycle
  assert_done_follows_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && memAck |=> fetchDone);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetchDone |=> !fetchDone);

  // R9: invalidate empties the window on the next edge
  assert_invalidate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |=> !winValid);

  // R6: an erroring fill leaves the window invalid
  assert_fill_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetchDone && fetchFromWin && !fetchOk |-> !winValid);

  // R5: a good fill leaves the window valid unless invalidated on the ack edge
  assert_fill_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetchDone && fetchFromWin && fetchOk && !$past(invalidate) |-> winValid);

  // R5: request length never zero and never beyond the window
  assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memLen != '0) && (memLen <= LEN_W'(CACHE_SIZE)));

endmodule

bind prefetch_window prefetch_window_checker #(
  .ADDR_W     (ADDR_W),
  .CACHE_SIZE (CACHE_SIZE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .memReq       (memReq),
  .memAck       (memAck),
  .memAddr      (memAddr),
  .memLen       (memLen),
  .fetchDone    (fetchDone),
  .fetchOk      (fetchOk),
  .fetchFromWin (fetchFromWin),
  .winValid     (winValid),
  .invalidate   (invalidate)
);

// File: tb/prefetch_window_bench.sv
module prefetch_window_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 16;
  localparam int CACHE_SIZE  = 8;
  localparam int PAGE_SIZE   = 64;
  localparam int FETCH_BYTES = 4;
  localparam int WR_BYTES    = 4;
  localparam int SIZE_W      = $clog2(FETCH_BYTES + 1);
  localparam int WSIZE_W     = $clog2(WR_BYTES + 1);
  localparam int LEN_W       = $clog2(CACHE_SIZE + 1);
  localparam int ERR_BASE    = 'hF000;
  localparam int WATCHDOG    = 100000;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     fetchReq = 1'b0;
  logic [ADDR_W-1:0]        fetchLinAddr = '0;
  logic [ADDR_W-1:0]        fetchOffset = '0;
  logic [ADDR_W-1:0]        fetchLimit = '0;
  logic [SIZE_W-1:0]        fetchSize = '0;
  logic                     fetchIsInst = 1'b0;
  logic                     pagingOn = 1'b0;
  logic                     fetchDone;
  logic                     fetchOk;
  logic                     fetchFromWin;
  logic [FETCH_BYTES*8-1:0] fetchData;
  logic                     memReq;
  logic [ADDR_W-1:0]        memAddr;
  logic [LEN_W-1:0]         memLen;
  logic                     memAck = 1'b0;
  logic                     memErr = 1'b0;
  logic [CACHE_SIZE*8-1:0]  memRdata = '0;
  logic                     wrEn = 1'b0;
  logic [ADDR_W-1:0]        wrAddr = '0;
  logic [WSIZE_W-1:0]       wrSize = '0;
  logic [WR_BYTES*8-1:0]    wrData = '0;
  logic                     invalidate = 1'b0;
  logic                     winValid;
  logic [ADDR_W-1:0]        winBase;
  logic [CACHE_SIZE*8-1:0]  winBytes;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_window #(
    .ADDR_W(ADDR_W), .CACHE_SIZE(CACHE_SIZE), .PAGE_SIZE(PAGE_SIZE),
    .FETCH_BYTES(FETCH_BYTES), .WR_BYTES(WR_BYTES)
  ) u_prefetch_window (
    .clk(clk), .rst_n(rst_n), .fetchReq(fetchReq), .fetchLinAddr(fetchLinAddr),
    .fetchOffset(fetchOffset), .fetchLimit(fetchLimit), .fetchSize(fetchSize),
    .fetchIsInst(fetchIsInst), .pagingOn(pagingOn), .fetchDone(fetchDone),
    .fetchOk(fetchOk), .fetchFromWin(fetchFromWin), .fetchData(fetchData),
    .memReq(memReq), .memAddr(memAddr), .memLen(memLen), .memAck(memAck),
    .memErr(memErr), .memRdata(memRdata), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrSize(wrSize), .wrData(wrData), .invalidate(invalidate),
    .winValid(winValid), .winBase(winBase), .winBytes(winBytes)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  int  cycles  = 0;
  bit  finished = 1'b0;

  // bench model of the window
  bit                      expValid = 1'b0;
  int                      expBase  = 0;
  logic [CACHE_SIZE*8-1:0] expBuf   = '0;

  function automatic logic [7:0] memByte(input int a);
    int m;
    m = a & 'hFFFF;
    return 8'(((m * 29) + (m >> 5)) ^ 'h5a);
  endfunction

  task automatic checkEq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doFetch(input int lin, input int off, input int lim, input int size,
                         input bit inst, input bit pg, input bit invAtAck, input bit poke);
    bit tryW, span, fill, err;
    int pOff, base, mAddr, mLen;
    string tag;
    logic [CACHE_SIZE*8-1:0]  rd;
    logic [FETCH_BYTES*8-1:0] expData;
    tryW = inst && ((off + CACHE_SIZE - 1) <= lim);
    pOff = lin % PAGE_SIZE;
    base = lin;
    if (pg && (pOff > PAGE_SIZE - CACHE_SIZE)) base = lin - pOff + PAGE_SIZE - CACHE_SIZE;
    span  = (lin - base + size) >= CACHE_SIZE;
    fill  = tryW && !span;
    mAddr = fill ? base : lin;
    mLen  = fill ? CACHE_SIZE : size;
    err   = mAddr >= ERR_BASE;
    tag   = !tryW ? "R2" : (span ? "R4" : "R3");
    for (int j = 0; j < CACHE_SIZE; j++) rd[8*j +: 8] = memByte(mAddr + j);
    expData = '0;
    for (int k = 0; k < FETCH_BYTES; k++)
      if (k < size) expData[8*k +: 8] = fill ? rd[8*(lin - base + k) +: 8] : rd[8*k +: 8];
    if (tryW) expBase = base;
    if (tryW && span) expValid = 1'b0;
    if (fill) begin
      if (err) expValid = 1'b0;
      else begin expValid = 1'b1; expBuf = rd; end
    end
    if (invAtAck) expValid = 1'b0;

    @(negedge clk);
    fetchLinAddr = ADDR_W'(lin);
    fetchOffset  = ADDR_W'(off);
    fetchLimit   = ADDR_W'(lim);
    fetchSize    = SIZE_W'(size);
    fetchIsInst  = inst;
    pagingOn     = pg;
    fetchReq     = 1'b1;
    @(negedge clk);
    fetchReq = poke;
    if (poke) fetchLinAddr = ADDR_W'(lin + 3);
    checkEq("R10", "memReq raised", 64'(memReq), 64'd1);
    checkEq(tag, "memAddr", 64'(memAddr), 64'(mAddr));
    checkEq(fill ? "R5" : tag, "memLen", 64'(memLen), 64'(mLen));
    memRdata   = rd;
    memErr     = err;
    memAck     = 1'b1;
    invalidate = invAtAck;
    @(negedge clk);
    memAck     = 1'b0;
    memErr     = 1'b0;
    invalidate = 1'b0;
    fetchReq   = 1'b0;
    checkEq("R10", "fetchDone", 64'(fetchDone), 64'd1);
    checkEq(fill ? "R6" : "R7", "fetchOk", 64'(fetchOk), 64'(!err));
    checkEq(tag, "fetchFromWin", 64'(fetchFromWin), 64'(fill));
    if (!err) checkEq(fill ? "R5" : "R11", "fetchData", 64'(fetchData), 64'(expData));
    checkEq(invAtAck ? "R9" : (fill ? "R5" : tag), "winValid", 64'(winValid), 64'(expValid));
    checkEq("R3", "winBase", 64'(winBase), 64'(expBase));
    if (expValid) checkEq("R5", "winBytes", 64'(winBytes), 64'(expBuf));
    if (poke) begin
      checkEq("R10", "busy request ignored", 64'(memReq), 64'd0);
      @(negedge clk);
      checkEq("R10", "no second request", 64'(memReq), 64'd0);
      checkEq("R10", "single done pulse", 64'(fetchDone), 64'd0);
    end
  endtask

  task automatic doWrite(input int addr, input int size, input logic [31:0] data);
    bit hit;
    hit = expValid && (addr >= expBase) && (addr + size <= expBase + CACHE_SIZE);
    if (hit)
      for (int k = 0; k < size; k++) expBuf[8*(addr - expBase + k) +: 8] = data[8*k +: 8];
    @(negedge clk);
    wrEn   = 1'b1;
    wrAddr = ADDR_W'(addr);
    wrSize = WSIZE_W'(size);
    wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    checkEq("R8", "winBytes after store", 64'(winBytes), 64'(expBuf));
    checkEq("R8", "winValid after store", 64'(winValid), 64'(expValid));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkEq("R1", "winValid", 64'(winValid), 64'd0);
    checkEq("R1", "winBase", 64'(winBase), 64'd0);
    checkEq("R1", "memReq", 64'(memReq), 64'd0);
    checkEq("R1", "fetchDone", 64'(fetchDone), 64'd0);

    // R3, R4, R5: every page offset, both paging settings, every size
    for (int pg = 0; pg < 2; pg++)
      for (int po = 0; po < PAGE_SIZE; po++)
        for (int sz = 1; sz <= FETCH_BYTES; sz++)
          doFetch('h1240 + po, 'h100 + po, 'hFFFF, sz, 1'b1, pg[0], 1'b0, 1'b0);

    // R2: limit boundary around offset + CACHE_SIZE - 1 == limit
    for (int off = 88; off <= 98; off++)
      doFetch('h3000 + off, off, 100, 2, 1'b1, 1'b0, 1'b0, 1'b0);
    // R2: offset near the top of the space must not wrap past the limit
    doFetch('h3400, 'hFFFC, 'hFFFF, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    // R2: data reads take the direct path and keep the window
    doFetch('h2000, 0, 'hFFFF, 4, 1'b1, 1'b0, 1'b0, 1'b0);
    doFetch('h2100, 0, 'hFFFF, 3, 1'b0, 1'b0, 1'b0, 1'b0);

    // R7: direct read error keeps the valid window
    doFetch('hF100, 0, 'hFFFF, 2, 1'b0, 1'b0, 1'b0, 1'b0);
    // R6: fill error drops the window
    doFetch('hF020, 0, 'hFFFF, 2, 1'b1, 1'b0, 1'b0, 1'b0);

    // R8: stores sweeping across both window edges
    doFetch('h2000, 0, 'hFFFF, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int a = -3; a <= CACHE_SIZE + 1; a++)
      for (int sz = 1; sz <= WR_BYTES; sz++)
        doWrite('h2000 + a, sz, 32'hA0B0C0D0 ^ 32'(a * 'h01010101 + sz));

    // R10: request poked while busy is ignored
    doFetch('h2200, 0, 'hFFFF, 2, 1'b1, 1'b1, 1'b0, 1'b1);

    // R9: invalidate pulse, then a store that must not patch
    @(negedge clk);
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    expValid = 1'b0;
    checkEq("R9", "winValid after invalidate", 64'(winValid), 64'd0);
    doWrite('h2202, 2, 32'h0000BEEF);

    // R9: invalidate on the same edge as a fill acknowledge wins
    doFetch('h2300, 0, 'hFFFF, 2, 1'b1, 1'b0, 1'b1, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule